// File: doc/BRIEF.md
# Registered Clock-Enable Strobe Generator

This block produces a one-cycle enable pulse once every `PERIOD` cycles of the core clock. Slower logic in the same clock domain uses the pulse to decide when to advance. No second clock is created. A free-running counter sets the period. The counter's terminal state is decoded one cycle ahead, and that decode loads a bank of flip-flops. Each enable output therefore comes straight from a register, and it is high in the same cycle that a combinational carry-out would mark.

There are `NUM_COPIES` enable outputs, so that each group of loads can take its own copy and the fanout is split. In parallel mode every copy is loaded from the look-ahead decode on the same edge. In chained mode the copies form a shift chain, and each copy follows the previous one by a single core cycle. This suits loads that can accept a fixed, known delay in exchange for shorter routes.

Top module: `strobe_gen`

## Requirements
- R1: While `rst_ni` is low, every bit of `en_o` is 0. The reset is asynchronous, so it clears the outputs without waiting for a clock edge.
- R2: Outside reset, `en_o[0]` is high for exactly one cycle in every `PERIOD` cycles and low in all other cycles (default `PERIOD` = 8).
- R3: After `rst_ni` rises, `en_o[0]` is first high in the cycle that follows the (`PERIOD`-1)-th rising clock edge.
- R4: With `MODE` = parallel (encoding 0), all bits of `en_o` are equal in every cycle.
- R5: With `MODE` = chained (encoding 1), `en_o[k]` equals `en_o[k-1]` as it was one cycle earlier. Copy k therefore first fires k cycles after copy 0.
- R6: In both modes, every copy pulses for one cycle, and its pulses are exactly `PERIOD` cycles apart.
- R7: A reset that arrives partway through a period discards the current phase. After release, the pulse timing restarts exactly as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_o | output | NUM_COPIES | Enable copies, each driven directly by a flip-flop |

## Verification
The hardest state to reach is a reset that lands while a pulse is still travelling down the chain. In that state, copy 0 has fired and the later copies have not. The bench keeps a count of edges since release, which tells it the phase of both instances. It drops reset on the very cycle that the parallel instance pulses, which is partway through the chained instance's period. It then checks that the outputs clear at once and that both instances restart from a fresh phase.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  typedef enum logic {
    FANOUT_PARALLEL = 1'b0,
    FANOUT_CHAIN    = 1'b1
  } fanout_mode_e;
endpackage

// File: rtl/period_counter.sv
module period_counter #(
  parameter int PERIOD = 8,
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          tc_next_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] PRE  = CW'(PERIOD - 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end

  // decode one cycle early so the registered enable lands on LAST
  assign tc_next_o = (cnt_q == PRE);
  assign cnt_o     = cnt_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R2
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0));
  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/enable_fanout.sv
module enable_fanout #(
  parameter int                      NUM_COPIES = 3,
  parameter strobe_pkg::fanout_mode_e MODE      = strobe_pkg::FANOUT_PARALLEL
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  output logic [NUM_COPIES-1:0] en_o
);
  logic [NUM_COPIES-1:0] en_q;

  generate
    if (MODE == strobe_pkg::FANOUT_PARALLEL) begin : g_par
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= '0;
        else         en_q <= {NUM_COPIES{load_i}};
      end
      // R4
      copies_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_q == {NUM_COPIES{en_q[0]}});
    end else if (NUM_COPIES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= '0;
        else         en_q <= {en_q[NUM_COPIES-2:0], load_i};
      end
      for (genvar k = 1; k < NUM_COPIES; k++) begin : g_stage_chk
        // R5
        stage_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          en_q[k] == $past(en_q[k-1]));
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= '0;
        else         en_q <= load_i;
      end
    end
  endgenerate

  assign en_o = en_q;
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen #(
  parameter int                      PERIOD     = 8,
  parameter int                      NUM_COPIES = 3,
  parameter strobe_pkg::fanout_mode_e MODE      = strobe_pkg::FANOUT_PARALLEL
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [NUM_COPIES-1:0] en_o
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW:0]   GAP  = (CW + 1)'(PERIOD - 1);

  logic [CW-1:0] cnt;
  logic          tc_next;

  period_counter #(.PERIOD(PERIOD)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_o     (cnt),
    .tc_next_o (tc_next)
  );

  enable_fanout #(.NUM_COPIES(NUM_COPIES), .MODE(MODE)) u_fan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tc_next),
    .en_o   (en_o)
  );

  // spacing monitor: cycles since last pulse of copy 0
  logic [CW:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           gap_q <= '0;
    else if (en_o[0])      gap_q <= '0;
    else if (gap_q != '1)  gap_q <= gap_q + (CW + 1)'(1);
  end

  // R2
  tc_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o[0] |-> (cnt == LAST));
  // R2
  one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o[0] |=> !en_o[0]);
  // R3
  spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o[0] |-> (gap_q == GAP));
  // R6
  no_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GAP);
endmodule

// File: tb/sim_strobe_gen.sv
module sim_strobe_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] en_a;
  logic [3:0] en_b;
  int         tests = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #2 clk_i = ~clk_i;

  strobe_gen #(.PERIOD(8), .NUM_COPIES(3), .MODE(strobe_pkg::FANOUT_PARALLEL)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_o(en_a));
  strobe_gen #(.PERIOD(5), .NUM_COPIES(4), .MODE(strobe_pkg::FANOUT_CHAIN)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_o(en_b));

  // edge index after release -> expected outputs
  localparam int         TBL_LEN = 10;
  localparam int         TBL_N [TBL_LEN] = '{1, 4, 5, 6, 7, 8, 9, 10, 14, 15};
  localparam logic [2:0] TBL_A [TBL_LEN] = '{3'b000, 3'b000, 3'b000, 3'b000, 3'b111,
                                             3'b000, 3'b000, 3'b000, 3'b000, 3'b111};
  localparam logic [3:0] TBL_B [TBL_LEN] = '{4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                             4'b0000, 4'b0001, 4'b0010, 4'b0001, 4'b0010};

  function automatic logic [2:0] model_a(int n);
    return (n >= 7 && (n - 7) % 8 == 0) ? 3'b111 : 3'b000;
  endfunction

  function automatic logic [3:0] model_b(int n);
    logic [3:0] r = '0;
    for (int k = 0; k < 4; k++)
      r[k] = (n - k >= 4) && ((n - k - 4) % 5 == 0);
    return r;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs low during reset
    repeat (3) @(negedge clk_i);
    chk("R1 u0 in reset", 8'(en_a), 8'd0);
    chk("R1 u1 in reset", 8'(en_b), 8'd0);

    // release, then walk the vector table (R3, R4, R5)
    rst_ni = 1'b1;
    begin
      int ti = 0;
      for (int n = 1; n <= 40; n++) begin
        @(negedge clk_i);
        if (ti < TBL_LEN && TBL_N[ti] == n) begin
          chk("R3 R4 u0 table", 8'(en_a), 8'(TBL_A[ti]));
          chk("R3 R5 u1 table", 8'(en_b), 8'(TBL_B[ti]));
          ti++;
        end
        chk("R2 R4 u0 model", 8'(en_a), 8'(model_a(n)));
        chk("R5 R6 u1 model", 8'(en_b), 8'(model_b(n)));
      end
    end

    // R1 + R7: reset while u0 pulses and u1 is mid-period
    for (int n = 41; n <= 47; n++) @(negedge clk_i);
    chk("R2 u0 before reset", 8'(en_a), 8'b111);
    rst_ni = 1'b0;
    #1;
    chk("R1 u0 async clear", 8'(en_a), 8'd0);
    chk("R1 u1 async clear", 8'(en_b), 8'd0);
    repeat (3) @(negedge clk_i);
    chk("R1 u0 held", 8'(en_a), 8'd0);
    rst_ni = 1'b1;
    for (int n = 1; n <= 24; n++) begin
      @(negedge clk_i);
      chk("R7 u0 restart", 8'(en_a), 8'(model_a(n)));
      chk("R7 u1 restart", 8'(en_b), 8'(model_b(n)));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule